// File: doc/BRIEF.md
# Byte-Packing SCSI DMA Controller

This block is a bus-master DMA engine that sits between a byte-wide peripheral DMA port and a 32-bit word memory. Software programs a start address and a byte count, chooses a direction, and sets the enable bit. Bytes then move whenever the peripheral raises its request line.

Going from peripheral to memory, the engine gathers incoming bytes into a big-endian pack register. It issues one full-word write when four bytes have been collected. Going from memory to peripheral, it fetches a word and hands out its bytes one at a time, starting at the lane the address points to. It fetches again after the last lane.

A terminal-count condition and the peripheral's own interrupt are merged into one pending flag and gated by an enable onto a single interrupt line. The terminal-count contribution is acknowledged by reading the control register.

Top module: `scsi_dma_engine`

## Requirements
- R1: After reset, the control, address and count registers read 0 (the request-pending bit aside), `irq_o` is low, and neither `mem_req` nor any peripheral strobe is asserted.
- R2: Control bit 10 (request pending) reads as the current level of `dev_req`.
- R3: A byte moves only while `dev_req` is high and control bit 7 (enable) is set. A request raised while enabled starts traffic, and so does setting enable while a request is already pending.
- R4: With control bit 6 set (peripheral to memory), the first byte packed lands in bits 31:24 and later bytes fill the lower lanes. After the fourth byte, one write of the packed word is made to word address `addr[AW-1:2]` with `mem_be` = 4'b1111, and the address then advances by 4.
- R5: Control bits 3:2 show how many bytes the pack register holds (0 to 3). They return to 0 after each full-word write.
- R6: With control bit 6 clear (memory to peripheral), the word at `addr[AW-1:2]` is fetched and each byte is taken from bits `(3-addr[1:0])*8 +: 8`. The address advances by 1 per byte, and a new word is fetched after the byte at `addr[1:0]` = 3, so an unaligned start sends only the remaining lanes.
- R7: The count register decrements by one per byte moved only when control bit 8 (count enable) is set. With count enable set and the count at zero, no byte moves.
- R8: Control bit 9 (terminal count) sets when a counted byte brings the count to zero.
- R9: Control bit 0 (interrupt pending) becomes (terminal count AND not yet read) OR `dev_irq`. `irq_o` becomes pending AND control bit 4 (interrupt enable). Each step takes one clock.
- R10: A CPU read of the control register while terminal count is set acknowledges it, and the pending bit drops unless `dev_irq` is high.
- R11: Writing 1 to control bit 5 (flush) clears the pack count, any partly packed bytes and terminal count. The bit itself reads back as 0, and discarded bytes never reach memory.
- R12: `dev_ack` (a byte was taken from `dev_rdata`) and `dev_wstb` (a byte is presented on `dev_wdata`) are single-cycle pulses and never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe, data one cycle later |
| csr_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data |
| dev_req | input | 1 | Peripheral DMA request |
| dev_irq | input | 1 | Peripheral interrupt |
| dev_rdata | input | 8 | Byte offered by the peripheral |
| dev_ack | output | 1 | Byte on `dev_rdata` was consumed |
| dev_wstb | output | 1 | Byte on `dev_wdata` is valid for the peripheral |
| dev_wdata | output | 8 | Byte sent to the peripheral |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte-lane enables |
| mem_ack | input | 1 | Memory acknowledge, one cycle; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench checks byte order in both directions. A packer that filled lanes from the bottom, or a reader that ignored the address lane, would show scrambled words in the write scoreboard or the wrong bytes at the peripheral. It starts a read at an unaligned address to catch an engine that always sends four bytes per fetch or fetches too often. It leaves three bytes partly packed and flushes them; a design that kept them would write a word mixing old and new bytes. It also runs with counting off and with a zero count, where a wrong design would keep decrementing or let bytes through. Finally, it probes the terminal-count acknowledge and interrupt masking, where a design that never cleared pending, or ignored the enable, would give a wrong status or `irq_o` level.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int REG_W      = 32;

  // control register bit positions
  localparam int CB_INTP  = 0;
  localparam int CB_FILL  = 2;
  localparam int CB_IEN   = 4;
  localparam int CB_FLUSH = 5;
  localparam int CB_DIR   = 6;
  localparam int CB_EN    = 7;
  localparam int CB_CNTEN = 8;
  localparam int CB_TC    = 9;
  localparam int CB_REQ   = 10;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_MWR, ST_MRD} eng_state_t;
endpackage

// File: rtl/sdma_packer.sv
module sdma_packer
  import sdma_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [7:0]                byte_i,
  input  logic                      clear_i,
  output logic [LANE_W-1:0]         fill_o,
  output logic [8*WORD_BYTES-1:0]   merged_o,
  output logic                      last_o
);
  logic [8*WORD_BYTES-1:0] pack_q;
  logic [LANE_W-1:0]       fill_q;

  always_comb begin
    merged_o = pack_q;
    merged_o[(WORD_BYTES - 1 - int'(fill_q)) * 8 +: 8] = byte_i;
  end

  assign last_o = (fill_q == LANE_W'(WORD_BYTES - 1));
  assign fill_o = fill_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pack_q <= '0;
      fill_q <= '0;
    end else if (load_i) begin
      if (last_o) begin
        pack_q <= '0;
        fill_q <= '0;
      end else begin
        pack_q <= merged_o;
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  // R5: a completed word empties the pack register
  assert_fill_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && last_o) |=> (fill_q == '0 && pack_q == '0));
  // R11: flush leaves nothing behind
  assert_flush_empty_R11: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (fill_q == '0));
endmodule

// File: rtl/sdma_irq.sv
module sdma_irq (
  input  logic clk,
  input  logic rst,
  input  logic tc_set_i,
  input  logic tc_clr_i,
  input  logic ctrl_rd_i,
  input  logic dev_irq_i,
  input  logic ien_i,
  output logic tc_o,
  output logic intp_o,
  output logic irq_o
);
  logic tc_q, seen_q, intp_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= 1'b0;
      seen_q <= 1'b0;
      intp_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (tc_clr_i)      tc_q <= 1'b0;
      else if (tc_set_i) tc_q <= 1'b1;
      if (tc_set_i || tc_clr_i)     seen_q <= 1'b0;
      else if (ctrl_rd_i && tc_q)   seen_q <= 1'b1;
      intp_q <= (tc_q && !seen_q) || dev_irq_i;
      irq_q  <= intp_q && ien_i;
    end
  end

  assign tc_o   = tc_q;
  assign intp_o = intp_q;
  assign irq_o  = irq_q;

  // R10: acknowledge only happens while terminal count is up
  assert_ack_needs_tc_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(seen_q) |-> $past(tc_q));
  // R9: unacknowledged terminal count raises pending
  assert_tc_pends_R9: assert property (@(posedge clk) disable iff (rst)
    (tc_q && !seen_q) |=> intp_q);
  // R9: interrupt line obeys the enable
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ien_i));
endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine
  import sdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csr_wr,
  input  logic          csr_rd,
  input  logic [1:0]    csr_sel,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic          dev_req,
  input  logic          dev_irq,
  input  logic [7:0]    dev_rdata,
  output logic          dev_ack,
  output logic          dev_wstb,
  output logic [7:0]    dev_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq_o
);
  eng_state_t      state_q;
  logic            ien_q, dir_q, en_q, cnten_q;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cnt_q;
  logic [31:0]     cache_q;
  logic            cache_vld_q;
  logic            ack_q, wstb_q, mreq_q, mwe_q;
  logic [7:0]      wbyte_q;
  logic [AW-3:0]   maddr_q;
  logic [31:0]     mwdata_q, rdata_q;
  logic [3:0]      mbe_q;

  logic wr_ctrl, wr_addr, wr_cnt, ctrl_rd, flush;
  logic go, pk_load, send, dec, tc_set;
  logic [LANE_W-1:0] pk_fill;
  logic [31:0]       pk_word;
  logic              pk_last;
  logic              tc, intp;
  logic [7:0]        lane_byte;

  assign wr_ctrl = csr_wr && csr_sel == SEL_CTRL;
  assign wr_addr = csr_wr && csr_sel == SEL_ADDR;
  assign wr_cnt  = csr_wr && csr_sel == SEL_CNT;
  assign ctrl_rd = csr_rd && csr_sel == SEL_CTRL;
  assign flush   = wr_ctrl && csr_wdata[CB_FLUSH];

  assign go      = en_q && dev_req && !(cnten_q && cnt_q == '0) && state_q == ST_IDLE;
  assign pk_load = go && dir_q;
  assign send    = go && !dir_q && cache_vld_q;
  assign dec     = pk_load || send;
  assign tc_set  = dec && cnten_q && cnt_q == CW'(1) && !wr_cnt;
  assign lane_byte = cache_q[(WORD_BYTES - 1 - int'(addr_q[LANE_W-1:0])) * 8 +: 8];

  sdma_packer u_pack (
    .clk(clk), .rst(rst), .load_i(pk_load), .byte_i(dev_rdata), .clear_i(flush),
    .fill_o(pk_fill), .merged_o(pk_word), .last_o(pk_last)
  );

  sdma_irq u_irq (
    .clk(clk), .rst(rst), .tc_set_i(tc_set), .tc_clr_i(flush), .ctrl_rd_i(ctrl_rd),
    .dev_irq_i(dev_irq), .ien_i(ien_q), .tc_o(tc), .intp_o(intp), .irq_o(irq_o)
  );

  // transfer sequencer and bus-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ack_q <= 1'b0; wstb_q <= 1'b0; wbyte_q <= '0;
      mreq_q <= 1'b0; mwe_q <= 1'b0; maddr_q <= '0; mwdata_q <= '0; mbe_q <= '0;
      cache_q <= '0; cache_vld_q <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      wstb_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (go) begin
          if (dir_q) begin
            ack_q <= 1'b1;
            if (pk_last) begin
              mreq_q <= 1'b1; mwe_q <= 1'b1; mbe_q <= 4'hF;
              maddr_q <= addr_q[AW-1:2]; mwdata_q <= pk_word;
              state_q <= ST_MWR;
            end else begin
              state_q <= ST_GAP;
            end
          end else if (cache_vld_q) begin
            wstb_q  <= 1'b1;
            wbyte_q <= lane_byte;
            if (addr_q[LANE_W-1:0] == '1) cache_vld_q <= 1'b0;
            state_q <= ST_GAP;
          end else begin
            mreq_q <= 1'b1; mwe_q <= 1'b0; mbe_q <= 4'hF;
            maddr_q <= addr_q[AW-1:2];
            state_q <= ST_MRD;
          end
        end
        ST_GAP: state_q <= ST_IDLE;
        ST_MWR: if (mem_ack) begin
          mreq_q <= 1'b0; mwe_q <= 1'b0; mbe_q <= '0;
          state_q <= ST_IDLE;
        end
        ST_MRD: if (mem_ack) begin
          mreq_q <= 1'b0; mbe_q <= '0;
          cache_q <= mem_rdata; cache_vld_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (flush || wr_addr) cache_vld_q <= 1'b0;
    end
  end

  // software-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0; dir_q <= 1'b0; en_q <= 1'b0; cnten_q <= 1'b0;
      addr_q <= '0; cnt_q <= '0; rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ien_q   <= csr_wdata[CB_IEN];
        dir_q   <= csr_wdata[CB_DIR];
        en_q    <= csr_wdata[CB_EN];
        cnten_q <= csr_wdata[CB_CNTEN];
      end
      if (wr_addr)                         addr_q <= csr_wdata[AW-1:0];
      else if (send)                       addr_q <= addr_q + AW'(1);
      else if (state_q == ST_MWR && mem_ack) addr_q <= addr_q + AW'(WORD_BYTES);
      if (wr_cnt)                          cnt_q <= csr_wdata[CW-1:0];
      else if (dec && cnten_q)             cnt_q <= cnt_q - CW'(1);
      if (csr_rd) begin
        case (csr_sel)
          SEL_CTRL: begin
            rdata_q <= '0;
            rdata_q[CB_INTP] <= intp;
            rdata_q[CB_FILL +: LANE_W] <= pk_fill;
            rdata_q[CB_IEN]   <= ien_q;
            rdata_q[CB_DIR]   <= dir_q;
            rdata_q[CB_EN]    <= en_q;
            rdata_q[CB_CNTEN] <= cnten_q;
            rdata_q[CB_TC]    <= tc;
            rdata_q[CB_REQ]   <= dev_req;
          end
          SEL_ADDR: rdata_q <= 32'(addr_q);
          SEL_CNT:  rdata_q <= 32'(cnt_q);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign csr_rdata = rdata_q;
  assign dev_ack   = ack_q;
  assign dev_wstb  = wstb_q;
  assign dev_wdata = wbyte_q;
  assign mem_req   = mreq_q;
  assign mem_we    = mwe_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwdata_q;
  assign mem_be    = mbe_q;

  // R12: peripheral strobes are isolated pulses
  assert_ack_gap_R12: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> !dev_ack);
  assert_wstb_gap_R12: assert property (@(posedge clk) disable iff (rst)
    dev_wstb |=> !dev_wstb);
  // R3: traffic needs request and enable
  assert_move_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (dev_ack || dev_wstb) |-> $past(dev_req && en_q));
  // R4: a write goes out only when the packer held three bytes plus the new one
  assert_word_full_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_we) |-> ($past(pk_fill) == LANE_W'(WORD_BYTES - 1)));
  assert_lanes_all_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be == 4'hF));
  // R7: uncounted mode keeps the count still
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!cnten_q && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: tb/sim_scsi_dma_engine.sv
module sim_scsi_dma_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        csr_wr = 0, csr_rd = 0;
  logic [1:0]  csr_sel = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        dev_irq = 0, dev_ack, dev_wstb, dev_req;
  logic [7:0]  dev_rdata, dev_wdata;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [3:0]  mem_be;
  logic        irq_o;

  scsi_dma_engine u0 (.*);

  // peripheral model
  logic [7:0] src_buf [64];
  logic [7:0] src_rp = 0, src_wp = 0;
  int         sink_left = 0;
  bit         dir_dev = 1;
  assign dev_req   = dir_dev ? (src_rp != src_wp) : (sink_left != 0);
  assign dev_rdata = src_buf[src_rp[5:0]];

  // memory model and scoreboards
  logic [31:0] mem_words [256];
  int          exp_idx_q[$];
  logic [31:0] exp_dat_q[$];
  logic [7:0]  exp_byte_q[$];
  int vectors = 0, miscompares = 0;
  int ack_seen = 0, wstb_seen = 0, rd_seen = 0, gap_err = 0;
  bit prev_ack = 0, prev_wstb = 0, done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int b);
    return mem_words[(b >> 2) & 255][(3 - (b & 3)) * 8 +: 8];
  endfunction

  always @(negedge clk) if (!rst) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1;
      if (mem_we) begin
        mem_words[mem_addr[7:0]] = mem_wdata;
        if (exp_idx_q.size() == 0) chk("R4 unexpected write", {2'b0, mem_addr}, 32'hFFFFFFFF);
        else begin
          chk("R4 write address", {2'b0, mem_addr}, exp_idx_q.pop_front());
          chk("R4 write data", mem_wdata, exp_dat_q.pop_front());
          chk("R4 lanes", {28'd0, mem_be}, 32'hF);
        end
      end else begin
        mem_rdata = mem_words[mem_addr[7:0]];
        rd_seen++;
      end
    end else mem_ack = 0;
    if (dev_wstb) begin
      wstb_seen++;
      if (exp_byte_q.size() == 0) chk("R6 unexpected byte", {24'd0, dev_wdata}, 32'hFFFFFFFF);
      else chk("R6 byte", {24'd0, dev_wdata}, {24'd0, exp_byte_q.pop_front()});
      if (sink_left > 0) sink_left--;
    end
    if (dev_ack) begin src_rp = src_rp + 1; ack_seen++; end
    if ((dev_ack && prev_ack) || (dev_wstb && prev_wstb)) gap_err++;
    prev_ack = dev_ack; prev_wstb = dev_wstb;
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); csr_wr = 1; csr_sel = s; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); csr_rd = 1; csr_sel = s;
    @(negedge clk); csr_rd = 0; d = csr_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    src_buf[src_wp[5:0]] = b; src_wp = src_wp + 1;
  endtask

  task automatic exp_wr(input int idx, input logic [31:0] d);
    exp_idx_q.push_back(idx); exp_dat_q.push_back(d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 256; i++) mem_words[i] = (32'h01020304 * (i + 1)) ^ 32'h5A5AA5A5;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R1 addr", v, 32'h0);
    rd(2'd2, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);

    // R2 mirror, R3 no movement while disabled
    push(8'h99); idle(10);
    rd(2'd0, v); chk("R2 req mirror high", v, 32'h400);
    chk("R3 disabled no ack", ack_seen, 0);
    src_rp = src_wp; idle(2);
    rd(2'd0, v); chk("R2 req mirror low", v, 32'h0);

    // R3/R4/R8: enable first, request arrives later
    wr(2'd1, 32'h40); wr(2'd2, 32'd8); wr(2'd0, 32'h1C0);
    exp_wr(16, 32'h11223344); exp_wr(17, 32'h55667788);
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    push(8'h55); push(8'h66); push(8'h77); push(8'h88);
    idle(60);
    chk("R4 writes done", exp_idx_q.size(), 0);
    rd(2'd1, v); chk("R4 addr advanced", v, 32'h48);
    rd(2'd2, v); chk("R7 count to zero", v, 32'h0);
    chk("R9 masked irq", {31'd0, irq_o}, 0);
    rd(2'd0, v); chk("R8 tc and pending", v, 32'h3C1);

    // R10 acknowledge by read
    idle(5);
    rd(2'd0, v); chk("R10 pending cleared", v, 32'h3C0);

    // R9 peripheral interrupt through the enable
    wr(2'd0, 32'h1D0); dev_irq = 1; idle(5);
    chk("R9 irq asserted", {31'd0, irq_o}, 1);
    rd(2'd0, v); chk("R9 pending from device", v, 32'h3D1);
    dev_irq = 0; idle(5);
    chk("R9 irq released", {31'd0, irq_o}, 0);

    // R5/R11 partial pack, then flush
    wr(2'd0, 32'h1C0); wr(2'd2, 32'd100);
    push(8'hAA); push(8'hBB); push(8'hCC); idle(30);
    rd(2'd0, v); chk("R5 fill of three", v, 32'h3CC);
    wr(2'd0, 32'h1E0);
    rd(2'd0, v); chk("R11 flush cleared", v, 32'h1C0);
    exp_wr(18, 32'hDDEEFF01);
    push(8'hDD); push(8'hEE); push(8'hFF); push(8'h01); idle(40);
    chk("R11 no stale bytes", exp_idx_q.size(), 0);
    rd(2'd2, v); chk("R7 counted bytes", v, 32'd93);

    // R7 uncounted mode
    wr(2'd0, 32'h0C0); wr(2'd2, 32'd5);
    exp_wr(19, 32'h10203040);
    push(8'h10); push(8'h20); push(8'h30); push(8'h40); idle(40);
    chk("R7 uncounted write", exp_idx_q.size(), 0);
    rd(2'd2, v); chk("R7 count held", v, 32'd5);
    rd(2'd1, v); chk("R4 addr after uncounted", v, 32'h50);

    // R7 zero count stalls
    wr(2'd2, 32'd0); wr(2'd0, 32'h1C0);
    base = ack_seen; push(8'h77); idle(20);
    chk("R7 zero count stall", ack_seen, base);
    rd(2'd0, v); chk("R7 stall status", v, 32'h5C0);
    wr(2'd0, 32'h0); src_rp = src_wp;

    // R6 memory to peripheral, unaligned start
    dir_dev = 0;
    wr(2'd1, 32'h81); wr(2'd2, 32'd6); wr(2'd0, 32'h180);
    for (int b = 'h81; b <= 'h86; b++) exp_byte_q.push_back(mem_byte(b));
    base = rd_seen; sink_left = 6; idle(60);
    chk("R6 bytes done", exp_byte_q.size(), 0);
    chk("R6 fetch count", rd_seen - base, 2);
    rd(2'd1, v); chk("R6 addr advanced", v, 32'h87);
    rd(2'd0, v); chk("R8 tc on read path", v, 32'h381);

    // R3 request pending before enable
    wr(2'd0, 32'h100); wr(2'd1, 32'hA2); wr(2'd2, 32'd3);
    base = wstb_seen; sink_left = 3; idle(20);
    chk("R3 held while disabled", wstb_seen, base);
    rd(2'd0, v); chk("R2 req pending", v, 32'h700);
    for (int b = 'hA2; b <= 'hA4; b++) exp_byte_q.push_back(mem_byte(b));
    base = rd_seen;
    wr(2'd0, 32'h180); idle(40);
    chk("R3 started by enable", exp_byte_q.size(), 0);
    chk("R6 crossed word", rd_seen - base, 2);

    chk("R12 strobe spacing", gap_err, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule